// File: doc/BRIEF.md
# 4x4 Integer Inverse Transform

This block turns a 4x4 block of signed transform coefficients back into residual samples for a block-based video decoder. Coefficients arrive one row of four per handshake. Each accepted row goes through a one-dimensional butterfly that uses no multipliers: the odd terms take half weights, made with arithmetic right shifts by one. The results are written into a transpose store. Once a whole block is stored, the same butterfly is applied down every column. Each result is rounded by adding 32 and shifting right arithmetically by six. The residuals leave one row per handshake.

The transpose store holds two banks. A new block can therefore be written while the previous one drains, and with both sides free-flowing the block moves one row per cycle in each direction. Both stream edges are valid/ready. A beat transfers on a rising edge where valid and ready are both high. The producer of a stream must hold its data stable while valid is high and ready is low. in_ready depends only on internal state and never on in_valid. out_valid and out_row depend only on internal state and never on out_ready. Dequantisation, prediction add and bitstream parsing are not part of this block.

Top module: `itx4x4`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The 1-D butterfly on inputs x0..x3 forms e0=x0+x2, e1=x0-x2, o0=(x1>>>1)-x3 and o1=x1+(x3>>>1). Its outputs at positions 0..3 are e0+o1, e1+o0, e1-o0 and e0-o1. Every >>> is an arithmetic shift that rounds toward minus infinity.
- R3: The row pass is applied first to each input row. The column pass is then applied to column j of those row results. Its output at position k becomes element j of output row k.
- R4: Each output element is (v+32)>>>6, where v is the result of the column pass, so negative values round toward minus infinity.
- R5: Element j of a 64-bit row occupies bits [16j+15:16j] as a 16-bit two's-complement value. Every 16-bit input, including all-extreme blocks, gives the exact result with no wrap of any intermediate value.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_row stays unchanged on the next cycle.
- R7: When both banks hold complete blocks that have not been read out, in_ready is 0 and rows presented on in_row are not taken.
- R8: With in_valid and out_ready held at 1, in_ready never drops, so one row per cycle is sustained in each direction.
- R9: Blocks leave in the order they arrived, and the rows of each block leave in the order 0, 1, 2, 3.
- R10: out_valid is 1 in the cycle after the edge that takes the fourth row of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A coefficient row is presented |
| in_ready | output | 1 | A row can be taken this cycle |
| in_row | input | 4*W (64) | Four signed coefficients, element j at bits [16j+15:16j] |
| out_valid | output | 1 | A residual row is presented |
| out_ready | input | 1 | The consumer takes the row this cycle |
| out_row | output | 4*W (64) | Four signed residuals, element j at bits [16j+15:16j] |

## Verification
The bench drives blocks at the extremes of the 16-bit range, including all-maximum, all-minimum and checkerboard patterns. A datapath that is too narrow wraps on these blocks and returns residuals with the wrong sign. Small DC blocks of 32 and -33 separate floor rounding from truncation, because a truncating shift gives 0 instead of -1. The bench fills both banks and then presents a stray row. A design that ignores in_ready overwrites a stored block, and the corruption shows in a later output. Full-rate streaming exposes a bank that is released one cycle late, which shows up as lost throughput. Random back-pressure exposes output rows that change while they wait to be taken.

// File: rtl/itx_pkg.sv
package itx_pkg;
  localparam int LANES     = 4;
  localparam int RND_SHIFT = 6;
  localparam int RND_BIAS  = 32;
  localparam int BANKS     = 2;
endpackage

// File: rtl/itx_bfly.sv
module itx_bfly #(
  parameter int IW = 16,
  parameter int OW = IW + 2
) (
  input  logic [itx_pkg::LANES*IW-1:0] x_flat,
  output logic [itx_pkg::LANES*OW-1:0] y_flat
);
  import itx_pkg::*;

  logic signed [OW-1:0] a [LANES];

  // sign-extend every lane to the output width before any arithmetic
  for (genvar i = 0; i < LANES; i++) begin : g_ext
    assign a[i] = {{(OW-IW){x_flat[i*IW+IW-1]}}, x_flat[i*IW +: IW]};
  end

  logic signed [OW-1:0] ev_s, ev_d, od_a, od_b;

  // R2: even pair from lanes 0/2, half-weight odd pair from lanes 1/3
  always_comb begin
    ev_s = a[0] + a[2];
    ev_d = a[0] - a[2];
    od_a = (a[1] >>> 1) - a[3];
    od_b = a[1] + (a[3] >>> 1);
  end

  assign y_flat[0*OW +: OW] = ev_s + od_b;
  assign y_flat[1*OW +: OW] = ev_d + od_a;
  assign y_flat[2*OW +: OW] = ev_d - od_a;
  assign y_flat[3*OW +: OW] = ev_s - od_b;
endmodule

// File: rtl/itx_tbuf.sv
module itx_tbuf #(
  parameter int DW = 18
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       wr_en,
  input  logic [itx_pkg::LANES*DW-1:0]               wr_row,
  output logic                                       wr_ready,
  input  logic                                       rd_en,
  output logic                                       rd_valid,
  output logic [1:0]                                 rd_idx,
  output logic [itx_pkg::LANES*itx_pkg::LANES*DW-1:0] rd_blk
);
  import itx_pkg::*;
  localparam int RowBits = LANES * DW;

  logic [RowBits-1:0] mem [BANKS][LANES];
  logic               wr_bank, rd_bank;
  logic [1:0]         wr_idx;
  logic [BANKS-1:0]   full;

  assign wr_ready = !full[wr_bank];
  assign rd_valid = full[rd_bank];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_bank][wr_idx] <= wr_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank <= 1'b0;
      rd_bank <= 1'b0;
      wr_idx  <= 2'd0;
      rd_idx  <= 2'd0;
      full    <= '0;
    end else begin
      if (wr_en) begin
        wr_idx <= wr_idx + 2'd1;
        if (wr_idx == 2'd3) begin
          full[wr_bank] <= 1'b1;
          wr_bank       <= ~wr_bank;
        end
      end
      if (rd_en) begin
        rd_idx <= rd_idx + 2'd1;
        if (rd_idx == 2'd3) begin
          full[rd_bank] <= 1'b0;
          rd_bank       <= ~rd_bank;
        end
      end
    end
  end

  for (genvar r = 0; r < LANES; r++) begin : g_rd
    assign rd_blk[r*RowBits +: RowBits] = mem[rd_bank][r];
  end

  // R9: rows of the read bank advance by one per accepted beat
  a_r9_read_order: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_idx == $past(rd_idx) + 2'd1);

  // R10: completing a block makes output data available next cycle
  a_r10_fill_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 2'd3) |=> rd_valid);
endmodule

// File: rtl/itx4x4.sv
module itx4x4 #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [4*W-1:0] in_row,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [4*W-1:0] out_row
);
  import itx_pkg::*;
  localparam int RW = W + 2;           // row-pass width
  localparam int CW = W + 4;           // column-pass width
  localparam int SW = CW + 1 - RND_SHIFT;   // bits kept after the shift

  logic [LANES*RW-1:0]       row_res;
  logic [LANES*LANES*RW-1:0] blk;
  logic [1:0]                rd_idx;
  logic                      wr_rdy, rd_vld;

  itx_bfly #(.IW(W), .OW(RW)) u_row (.x_flat(in_row), .y_flat(row_res));

  itx_tbuf #(.DW(RW)) u_tbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(in_valid && wr_rdy), .wr_row(row_res), .wr_ready(wr_rdy),
    .rd_en(rd_vld && out_ready), .rd_valid(rd_vld),
    .rd_idx(rd_idx), .rd_blk(blk)
  );

  assign in_ready  = wr_rdy;
  assign out_valid = rd_vld;

  // R3: one column butterfly per column of the stored row results
  for (genvar j = 0; j < LANES; j++) begin : g_col
    logic [LANES*RW-1:0] col_in;
    logic [LANES*CW-1:0] col_out;
    logic signed [CW-1:0] v;
    logic signed [CW:0]   biased;
    logic [SW-1:0]        kept;

    for (genvar r = 0; r < LANES; r++) begin : g_gather
      assign col_in[r*RW +: RW] = blk[(r*LANES + j)*RW +: RW];
    end

    itx_bfly #(.IW(RW), .OW(CW)) u_col (.x_flat(col_in), .y_flat(col_out));

    // R4: add half an LSB of the shift, then floor
    assign v      = col_out[rd_idx*CW +: CW];
    assign biased = {v[CW-1], v} + (CW+1)'(RND_BIAS);
    assign kept   = biased[CW:RND_SHIFT];
    assign out_row[j*W +: W] = {{(W-SW){kept[SW-1]}}, kept};
  end

  // R6: a stalled output beat keeps its valid and its data
  a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_row));
endmodule

// File: tb/itx4x4_test.sv
`timescale 1ns/1ps
module itx4x4_test;
  localparam int NB   = 40;
  localparam int NDIR = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_row = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_row;

  int checks = 0;
  int fails  = 0;
  int coef [NB][4][4];
  int expv [NB][4][4];
  int stalls = 0;
  bit done = 0;

  always #4 clk = ~clk;

  itx4x4 uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
              .in_row(in_row), .out_valid(out_valid), .out_ready(out_ready),
              .out_row(out_row));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void bf(input int x0, x1, x2, x3, output int y0, y1, y2, y3);
    int e0, e1, o0, o1;
    e0 = x0 + x2;  e1 = x0 - x2;
    o0 = (x1 >>> 1) - x3;  o1 = x1 + (x3 >>> 1);
    y0 = e0 + o1;  y1 = e1 + o0;  y2 = e1 - o0;  y3 = e0 - o1;
  endfunction

  function automatic void model(input int b);
    int t [4][4];
    int c0, c1, c2, c3;
    for (int r = 0; r < 4; r++)
      bf(coef[b][r][0], coef[b][r][1], coef[b][r][2], coef[b][r][3],
         t[r][0], t[r][1], t[r][2], t[r][3]);
    for (int j = 0; j < 4; j++) begin
      bf(t[0][j], t[1][j], t[2][j], t[3][j], c0, c1, c2, c3);
      expv[b][0][j] = (c0 + 32) >>> 6;
      expv[b][1][j] = (c1 + 32) >>> 6;
      expv[b][2][j] = (c2 + 32) >>> 6;
      expv[b][3][j] = (c3 + 32) >>> 6;
    end
  endfunction

  function automatic logic [63:0] pack_in(input int b, input int r);
    logic [63:0] v;
    for (int j = 0; j < 4; j++) v[j*16 +: 16] = 16'(coef[b][r][j]);
    return v;
  endfunction

  function automatic logic [63:0] pack_exp(input int b, input int r);
    logic [63:0] v;
    for (int j = 0; j < 4; j++) v[j*16 +: 16] = 16'(expv[b][r][j]);
    return v;
  endfunction

  task automatic send_block(input int b, input bit full_rate);
    for (int r = 0; r < 4; r++) begin
      if (!full_rate)
        while ($urandom % 3 == 0) begin
          @(negedge clk); in_valid = 1'b0;
        end
      @(negedge clk);
      in_valid = 1'b1;
      in_row   = pack_in(b, r);
      #1;
      while (!in_ready) begin
        if (full_rate) stalls++;
        @(negedge clk); #1;
      end
    end
  endtask

  task automatic drive(input int first, input int last, input bit full_rate);
    for (int b = first; b <= last; b++) send_block(b, full_rate);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic consume(input int first, input int last, input bit full_rate);
    int b = first;
    int r = 0;
    bit pend = 0;
    logic [63:0] held = '0;
    while (b <= last) begin
      @(negedge clk);
      out_ready = full_rate ? 1'b1 : ($urandom % 4 != 0);
      #1;
      if (pend) begin
        check(out_valid === 1'b1 && out_row === held, "R6 stalled beat changed",
              out_row, held);
      end
      pend = 0;
      if (out_valid) begin
        if (out_ready) begin
          check(out_row === pack_exp(b, r),
                (b < NDIR) ? "R5 R2 R3 R4 R9 directed" : "R2 R3 R4 R9 random",
                out_row, pack_exp(b, r));
          r++;
          if (r == 4) begin r = 0; b++; end
        end else begin
          pend = 1; held = out_row;
        end
      end
    end
    @(negedge clk); out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int r = 0; r < 4; r++)
      for (int j = 0; j < 4; j++) begin
        coef[0][r][j] = 32767;
        coef[1][r][j] = -32768;
        coef[2][r][j] = ((r + j) % 2 == 0) ? 32767 : -32768;
        coef[3][r][j] = (j < 2) ? ((r % 2 == 0) ? 32767 : -32768) : ((r % 2 == 0) ? -32768 : 32767);
        coef[4][r][j] = 0;
        coef[5][r][j] = 0;
        coef[6][r][j] = 0;
      end
    coef[4][0][0] = 32;
    coef[5][0][0] = -33;
    for (int b = NDIR; b < NB; b++)
      for (int r = 0; r < 4; r++)
        for (int j = 0; j < 4; j++)
          coef[b][r][j] = (b % 2 == 0) ? int'($urandom & 32'hFFFF) - 32768
                                       : int'($urandom % 512) - 256;
    for (int b = 0; b < NB; b++) model(b);

    // R1: reset state
    #2;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1 during reset",
          {62'd0, out_valid, in_ready}, 64'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1 after reset",
          {62'd0, out_valid, in_ready}, 64'd1);

    // R10: output appears the cycle after the fourth row is taken
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      in_valid = 1'b1; in_row = pack_in(0, r);
      #1;
      if (r == 3)
        check(out_valid === 1'b0, "R10 valid before block complete",
              {63'd0, out_valid}, 64'd0);
    end
    @(negedge clk); in_valid = 1'b0; #1;
    check(out_valid === 1'b1, "R10 valid after fourth row", {63'd0, out_valid}, 64'd1);

    // R7: second bank fills, then stray rows must be refused
    for (int r = 0; r < 4; r++) begin
      @(negedge clk); in_valid = 1'b1; in_row = pack_in(1, r);
    end
    @(negedge clk); #1;
    check(in_ready === 1'b0, "R7 ready low with both banks full",
          {63'd0, in_ready}, 64'd0);
    in_valid = 1'b1; in_row = 64'h7FFF_8000_1234_ABCD;
    repeat (3) @(negedge clk);
    #1;
    check(in_ready === 1'b0 && out_row === pack_exp(0, 0), "R7 stray row ignored",
          out_row, pack_exp(0, 0));
    in_valid = 1'b0;

    fork
      drive(2, 29, 1'b0);
      consume(0, 29, 1'b0);
    join

    fork
      drive(30, NB - 1, 1'b1);
      consume(30, NB - 1, 1'b1);
    join
    check(stalls == 0, "R8 full-rate stall cycles", 64'(stalls), 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule